// File: doc/BRIEF.md
# Single-Precision Floating-Point Add/Subtract Unit

This block adds or subtracts two 32-bit binary floating-point words and returns a rounded 32-bit word with three status flags. Each word has one sign bit, an 8-bit exponent biased by 127 and a 23-bit fraction. A normal value carries an implied leading one. Operands go in on a cycle with `in_valid` high, and `op_sub` picks a+b or a−b. The result comes out two clocks later, marked by `out_valid`.

Internally the flow has four steps:
1. The operand with the larger magnitude is chosen, and the smaller one is shifted right to the same exponent. Three extra low-order bits (guard, round, sticky) are kept.
2. The aligned significands are added or subtracted.
3. The sum is normalized by a one-bit right shift on carry-out, or by a leading-zero-count left shift after cancellation.
4. The result is rounded to nearest, ties to even.

Infinities and NaNs bypass the arithmetic. An exponent that grows too large gives a signed infinity and raises the overflow flag. An exponent that falls too small gives a signed zero and raises the underflow flag.

Top module: `fp32_addsub_unit`

## Requirements
- R1: Operands sampled on a rising edge with `in_valid` high produce `out_valid` high exactly two rising edges later; `out_valid` is low in every other cycle. While `rst` is high, `out_valid`, `result` and all flags are driven to zero.
- R2: With `op_sub` = 0 the unit computes a+b; with `op_sub` = 1 it computes a−b by inverting the sign bit (bit 31) of b before the addition.
- R3: For finite operands whose result is neither overflowed nor underflowed, `result` equals the exact sum rounded to a 24-bit significand, to nearest with ties to even.
- R4: Operand decoding: exponent field (bits 30:23) 0 denotes zero or a subnormal of value 0.f × 2^-126; exponent 1..254 denotes 1.f × 2^(e−127); exponent 255 denotes infinity (fraction 0) or NaN (fraction nonzero).
- R5: An exactly zero sum returns −0 (0x80000000) when both effective operands are negative, and +0 (0x00000000) otherwise.
- R6: When one operand is zero and the other is a normal finite value, the result is that other operand unchanged (with its sign inverted if it is b and `op_sub` = 1).
- R7: If the rounded result exponent reaches 255, `result` is a correctly signed infinity (exponent 255, fraction 0) and `flag_ovf` is 1.
- R8: If a nonzero finite result normalizes to a biased exponent of 0 or below (checked before rounding), `result` is a correctly signed zero and `flag_unf` is 1; no subnormal word is ever output.
- R9: Any NaN operand, quiet or signalling, of either sign yields the quiet NaN 0x7FC00000 with all flags 0.
- R10: An infinity combined with a finite value, or with an infinity of the same effective sign, yields that infinity. Infinities of opposite effective sign yield 0x7FC00000 with `flag_inv` = 1. At most one of the three flags is 1 on any output.
- R11: Subtracting operands that are nearly equal is exact; for example, 1.0 − (1 − 2^-24) returns 2^-24 (0x33800000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and `op_sub` are presented this cycle |
| op_sub | input | 1 | 0 = a+b, 1 = a−b |
| a_in | input | 32 | Operand a |
| b_in | input | 32 | Operand b |
| out_valid | output | 1 | `result` and flags hold a new answer |
| result | output | 32 | Rounded floating-point result |
| flag_ovf | output | 1 | Result overflowed to infinity |
| flag_unf | output | 1 | Result underflowed and was flushed to zero |
| flag_inv | output | 1 | Opposite-signed infinities were combined |

## Verification
The latency property assumes that `in_valid` stays low while `rst` is high, because it relates `out_valid` to `in_valid` two edges back. The bench holds `in_valid` low through reset and drives all inputs on the falling edge. The bench mixes operands from four groups: directed values near the rounding ties, the overflow and underflow edges and the special encodings; fully random words; operand pairs with close exponents; and pairs that differ only in their low bits and are subtracted. This mix reaches both normalization directions as well as the flush and saturate paths.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  // Classification of an unpacked operand.
  typedef enum logic [1:0] {
    KIND_FINITE = 2'd0,
    KIND_INF    = 2'd1,
    KIND_NAN    = 2'd2
  } fp_kind_e;

  // Special-result selector computed before the arithmetic path.
  typedef enum logic [1:0] {
    SP_NONE = 2'd0,
    SP_INF  = 2'd1,
    SP_QNAN = 2'd2
  } spec_e;

endpackage

// File: rtl/fp_unpack.sv
module fp_unpack
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output logic                  sign,
  output logic [EXP_W-1:0]      exp_eff,
  output logic [FRAC_W:0]       mant,
  output fp_kind_e              kind
);

  localparam int W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  ef;
  logic [FRAC_W-1:0] fr;
  logic              e_zero;
  logic              e_ones;

  always_comb begin
    ef      = word[W-2:FRAC_W];
    fr      = word[FRAC_W-1:0];
    sign    = word[W-1];
    e_zero  = ~|ef;
    e_ones  = &ef;
    // subnormals and zero share the minimum normal exponent, hidden bit 0
    exp_eff = e_zero ? EXP_W'(1) : ef;
    mant    = {~e_zero, fr};
    if (!e_ones)      kind = KIND_FINITE;
    else if (fr == '0) kind = KIND_INF;
    else               kind = KIND_NAN;
  end

endmodule

// File: rtl/fp_align.sv
module fp_align
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int GRS    = 3
) (
  input  logic                  sign_a,
  input  logic [EXP_W-1:0]      exp_a,
  input  logic [FRAC_W:0]       mant_a,
  input  fp_kind_e              kind_a,
  input  logic                  sign_b,
  input  logic [EXP_W-1:0]      exp_b,
  input  logic [FRAC_W:0]       mant_b,
  input  fp_kind_e              kind_b,
  input  logic                  op_sub,
  output logic                  eff_sub,
  output logic                  big_sign,
  output logic                  zero_sign,
  output logic [EXP_W-1:0]      exp_big,
  output logic [FRAC_W+GRS:0]   big_m,
  output logic [FRAC_W+GRS:0]   small_m,
  output spec_e                 spec,
  output logic                  spec_sign,
  output logic                  spec_inv
);

  localparam int MAN_W = FRAC_W + 1;
  localparam int WK    = MAN_W + GRS;

  logic             sb_eff;
  logic             a_big;
  logic [EXP_W-1:0] exp_small;
  logic [EXP_W-1:0] diff;
  logic [WK-1:0]    ext_small;
  logic [WK-1:0]    shifted;
  logic [WK-1:0]    lost_mask;
  logic             sticky;

  always_comb begin
    sb_eff    = sign_b ^ op_sub;
    eff_sub   = sign_a ^ sb_eff;
    zero_sign = sign_a & sb_eff;

    // order by magnitude so the difference never goes negative
    a_big     = {exp_a, mant_a} >= {exp_b, mant_b};
    big_sign  = a_big ? sign_a : sb_eff;
    exp_big   = a_big ? exp_a : exp_b;
    exp_small = a_big ? exp_b : exp_a;
    big_m     = {(a_big ? mant_a : mant_b), {GRS{1'b0}}};
    ext_small = {(a_big ? mant_b : mant_a), {GRS{1'b0}}};
    diff      = exp_big - exp_small;

    lost_mask = '0;
    if (diff >= EXP_W'(WK)) begin
      shifted = '0;
      sticky  = |ext_small;
    end else begin
      shifted   = ext_small >> diff;
      lost_mask = ~({WK{1'b1}} << diff);
      sticky    = |(ext_small & lost_mask);
    end
    small_m = {shifted[WK-1:1], shifted[0] | sticky};

    spec      = SP_NONE;
    spec_sign = 1'b0;
    spec_inv  = 1'b0;
    if (kind_a == KIND_NAN || kind_b == KIND_NAN) begin
      spec = SP_QNAN;
    end else if (kind_a == KIND_INF && kind_b == KIND_INF) begin
      if (eff_sub) begin
        spec     = SP_QNAN;
        spec_inv = 1'b1;
      end else begin
        spec      = SP_INF;
        spec_sign = sign_a;
      end
    end else if (kind_a == KIND_INF) begin
      spec      = SP_INF;
      spec_sign = sign_a;
    end else if (kind_b == KIND_INF) begin
      spec      = SP_INF;
      spec_sign = sb_eff;
    end
  end

endmodule

// File: rtl/fp_lzc.sv
module fp_lzc #(
  parameter int W = 27
) (
  input  logic [W-1:0]           vec,
  output logic [$clog2(W+1)-1:0] count
);

  localparam int CW = $clog2(W + 1);

  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) count = CW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/fp_addnorm.sv
module fp_addnorm #(
  parameter int EXP_W = 8,
  parameter int WK    = 27
) (
  input  logic               eff_sub,
  input  logic [EXP_W-1:0]   exp_big,
  input  logic [WK-1:0]      big_m,
  input  logic [WK-1:0]      small_m,
  output logic               sum_zero,
  output logic [EXP_W+1:0]   exp_n,
  output logic [WK-1:0]      norm_m
);

  localparam int CW = $clog2(WK + 1);
  localparam int XE = EXP_W + 2;

  logic [WK:0]   raw;
  logic [CW-1:0] lz;

  assign raw = eff_sub ? ({1'b0, big_m} - {1'b0, small_m})
                       : ({1'b0, big_m} + {1'b0, small_m});

  fp_lzc #(.W(WK)) u_lzc (
    .vec   (raw[WK-1:0]),
    .count (lz)
  );

  always_comb begin
    sum_zero = (raw == '0);
    if (raw[WK]) begin
      // carry out: one step right, fold the dropped bit into sticky
      norm_m = {raw[WK:2], raw[1] | raw[0]};
      exp_n  = {2'b00, exp_big} + XE'(1);
    end else begin
      norm_m = raw[WK-1:0] << lz;
      exp_n  = {2'b00, exp_big} - XE'(lz);
    end
  end

endmodule

// File: rtl/fp_round.sv
module fp_round
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int GRS    = 3
) (
  input  logic                 sign,
  input  logic                 zero_sign,
  input  logic                 sum_zero,
  input  logic [EXP_W+1:0]     exp_n,
  input  logic [FRAC_W+GRS:0]  norm_m,
  input  spec_e                spec,
  input  logic                 spec_sign,
  output logic [EXP_W+FRAC_W:0] word,
  output logic                 ovf,
  output logic                 unf
);

  localparam int MAN_W = FRAC_W + 1;
  localparam int WK    = MAN_W + GRS;
  localparam int XE    = EXP_W + 2;
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam logic [EXP_W-1:0] E_ONES = '1;

  logic [MAN_W-1:0] keep;
  logic             guard;
  logic             tail;
  logic             up;
  logic [MAN_W:0]   rsum;
  logic [XE-1:0]    exp_r;
  logic             too_small;
  logic             too_big;

  always_comb begin
    keep      = norm_m[WK-1:GRS];
    guard     = norm_m[GRS-1];
    tail      = |norm_m[GRS-2:0];
    up        = guard & (tail | keep[0]);
    rsum      = {1'b0, keep} + (MAN_W+1)'(up);
    exp_r     = exp_n + XE'(rsum[MAN_W]);
    too_small = exp_n[XE-1] | (exp_n == '0);
    too_big   = !exp_r[XE-1] && (exp_r[XE-2:0] >= (XE-1)'(E_ONES));

    word = '0;
    ovf  = 1'b0;
    unf  = 1'b0;
    if (spec == SP_QNAN) begin
      word = {1'b0, E_ONES, 1'b1, {(FRAC_W-1){1'b0}}};
    end else if (spec == SP_INF) begin
      word = {spec_sign, E_ONES, {FRAC_W{1'b0}}};
    end else if (sum_zero) begin
      word = {zero_sign, {(W-1){1'b0}}};
    end else if (too_small) begin
      word = {sign, {(W-1){1'b0}}};
      unf  = 1'b1;
    end else if (too_big) begin
      word = {sign, E_ONES, {FRAC_W{1'b0}}};
      ovf  = 1'b1;
    end else begin
      word = {sign, exp_r[EXP_W-1:0],
              (rsum[MAN_W] ? {FRAC_W{1'b0}} : rsum[FRAC_W-1:0])};
    end
  end

endmodule

// File: rtl/fp32_addsub_unit.sv
module fp32_addsub_unit
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   op_sub,
  input  logic [EXP_W+FRAC_W:0]  a_in,
  input  logic [EXP_W+FRAC_W:0]  b_in,
  output logic                   out_valid,
  output logic [EXP_W+FRAC_W:0]  result,
  output logic                   flag_ovf,
  output logic                   flag_unf,
  output logic                   flag_inv
);

  localparam int GRS   = 3;
  localparam int MAN_W = FRAC_W + 1;
  localparam int WK    = MAN_W + GRS;
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int NOPS  = 2;

  // ---------------- stage 0: unpack and align ----------------
  logic [W-1:0]     opw     [NOPS];
  logic             op_sign [NOPS];
  logic [EXP_W-1:0] op_exp  [NOPS];
  logic [MAN_W-1:0] op_mant [NOPS];
  fp_kind_e         op_kind [NOPS];

  assign opw[0] = a_in;
  assign opw[1] = b_in;

  for (genvar gi = 0; gi < NOPS; gi++) begin : g_unpack
    fp_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
      .word    (opw[gi]),
      .sign    (op_sign[gi]),
      .exp_eff (op_exp[gi]),
      .mant    (op_mant[gi]),
      .kind    (op_kind[gi])
    );
  end

  logic             al_eff_sub, al_big_sign, al_zero_sign, al_spec_sign, al_spec_inv;
  logic [EXP_W-1:0] al_exp_big;
  logic [WK-1:0]    al_big_m, al_small_m;
  spec_e            al_spec;

  fp_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GRS(GRS)) u_align (
    .sign_a    (op_sign[0]),
    .exp_a     (op_exp[0]),
    .mant_a    (op_mant[0]),
    .kind_a    (op_kind[0]),
    .sign_b    (op_sign[1]),
    .exp_b     (op_exp[1]),
    .mant_b    (op_mant[1]),
    .kind_b    (op_kind[1]),
    .op_sub    (op_sub),
    .eff_sub   (al_eff_sub),
    .big_sign  (al_big_sign),
    .zero_sign (al_zero_sign),
    .exp_big   (al_exp_big),
    .big_m     (al_big_m),
    .small_m   (al_small_m),
    .spec      (al_spec),
    .spec_sign (al_spec_sign),
    .spec_inv  (al_spec_inv)
  );

  // ---------------- stage 1 register ----------------
  logic             s1_valid;
  logic             s1_eff_sub, s1_big_sign, s1_zero_sign, s1_spec_sign, s1_spec_inv;
  logic [EXP_W-1:0] s1_exp_big;
  logic [WK-1:0]    s1_big_m, s1_small_m;
  spec_e            s1_spec;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_eff_sub   <= al_eff_sub;
      s1_big_sign  <= al_big_sign;
      s1_zero_sign <= al_zero_sign;
      s1_spec_sign <= al_spec_sign;
      s1_spec_inv  <= al_spec_inv;
      s1_exp_big   <= al_exp_big;
      s1_big_m     <= al_big_m;
      s1_small_m   <= al_small_m;
      s1_spec      <= al_spec;
    end
  end

  // ---------------- stage 1: add, normalize, round ----------------
  logic             an_zero;
  logic [EXP_W+1:0] an_exp;
  logic [WK-1:0]    an_norm;

  fp_addnorm #(.EXP_W(EXP_W), .WK(WK)) u_addnorm (
    .eff_sub  (s1_eff_sub),
    .exp_big  (s1_exp_big),
    .big_m    (s1_big_m),
    .small_m  (s1_small_m),
    .sum_zero (an_zero),
    .exp_n    (an_exp),
    .norm_m   (an_norm)
  );

  logic [W-1:0] rd_word;
  logic         rd_ovf, rd_unf;

  fp_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GRS(GRS)) u_round (
    .sign      (s1_big_sign),
    .zero_sign (s1_zero_sign),
    .sum_zero  (an_zero),
    .exp_n     (an_exp),
    .norm_m    (an_norm),
    .spec      (s1_spec),
    .spec_sign (s1_spec_sign),
    .word      (rd_word),
    .ovf       (rd_ovf),
    .unf       (rd_unf)
  );

  // ---------------- output register ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_ovf  <= 1'b0;
      flag_unf  <= 1'b0;
      flag_inv  <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        result   <= rd_word;
        flag_ovf <= rd_ovf;
        flag_unf <= rd_unf;
        flag_inv <= s1_spec_inv;
      end
    end
  end

endmodule

// File: rtl/fp32_addsub_chk.sv
module fp32_addsub_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  op_sub,
  input logic [EXP_W+FRAC_W:0] a_in,
  input logic [EXP_W+FRAC_W:0] b_in,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] result,
  input logic                  flag_ovf,
  input logic                  flag_unf,
  input logic                  flag_inv
);

  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [EXP_W-1:0] E_ONES = '1;
  localparam logic [W-1:0] QNAN = {1'b0, E_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

  logic a_nan, b_nan;
  assign a_nan = (a_in[W-2:FRAC_W] == E_ONES) && (a_in[FRAC_W-1:0] != '0);
  assign b_nan = (b_in[W-2:FRAC_W] == E_ONES) && (b_in[FRAC_W-1:0] != '0);

  // R1: two-edge latency from accepted operands to out_valid
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid, 2));

  // R10: flags never coincide
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0({flag_ovf, flag_unf, flag_inv}));

  // R7: overflow always carries an infinity encoding
  p_ovf_inf_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flag_ovf) |-> (result[W-2:0] == {E_ONES, {FRAC_W{1'b0}}}));

  // R8: underflow always carries a zero encoding
  p_unf_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flag_unf) |-> (result[W-2:0] == '0));

  // R8: no subnormal word leaves the unit
  p_no_subnormal_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !((result[W-2:FRAC_W] == '0) && (result[FRAC_W-1:0] != '0)));

  // R10: invalid flag pairs with the quiet NaN
  p_inv_qnan_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flag_inv) |-> (result == QNAN));

  // R9: NaN operands become the quiet NaN with no flags
  p_nan_in_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid, 2) && ($past(a_nan, 2) || $past(b_nan, 2)))
      |-> (out_valid && result == QNAN && !flag_ovf && !flag_unf && !flag_inv));

  // R1: outputs stay cleared while reset is held
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && result == '0 && !flag_ovf && !flag_unf && !flag_inv));

endmodule

bind fp32_addsub_unit fp32_addsub_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/tb_fp32_addsub_unit.sv
module tb_fp32_addsub_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        op_sub = 1'b0;
  logic [31:0] a_in = '0;
  logic [31:0] b_in = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_ovf, flag_unf, flag_inv;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [31:0] rs = 32'h1234_5679;

  logic [35:0] exp_q[$];
  string       tag_q[$];

  localparam logic [31:0] QNAN = 32'h7FC0_0000;

  always #10 clk = ~clk;

  fp32_addsub_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
    .a_in(a_in), .b_in(b_in), .out_valid(out_valid), .result(result),
    .flag_ovf(flag_ovf), .flag_unf(flag_unf), .flag_inv(flag_inv)
  );

  function automatic logic [31:0] rnd();
    rs ^= rs << 13;
    rs ^= rs >> 17;
    rs ^= rs << 5;
    return rs;
  endfunction

  // Behavioural reference: returns {ovf, unf, inv, word}
  function automatic logic [34:0] ref_model(input logic [31:0] a, input logic [31:0] b,
                                            input logic sub);
    logic sa, sb, st, s;
    int ea, eb, et, d, p, en, sh;
    longint ma, mb, mt, big_v, small_v, tot, mag, keep, rem, half;
    sa = a[31]; sb = b[31] ^ sub;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    ma = longint'(a[22:0]); mb = longint'(b[22:0]);
    if ((ea == 255 && ma != 0) || (eb == 255 && mb != 0)) return {3'b000, QNAN};
    if (ea == 255 && eb == 255)
      return (sa != sb) ? {3'b001, QNAN} : {3'b000, sa, 8'hFF, 23'h0};
    if (ea == 255) return {3'b000, sa, 8'hFF, 23'h0};
    if (eb == 255) return {3'b000, sb, 8'hFF, 23'h0};
    if (ea == 0) ea = 1; else ma = ma + (64'sd1 <<< 23);
    if (eb == 0) eb = 1; else mb = mb + (64'sd1 <<< 23);
    if (eb > ea) begin
      st = sa; sa = sb; sb = st;
      et = ea; ea = eb; eb = et;
      mt = ma; ma = mb; mb = mt;
    end
    d = ea - eb;
    big_v = ma <<< 34;
    if (d <= 34) small_v = mb <<< (34 - d);
    else         small_v = (mb != 0) ? 64'sd1 : 64'sd0;
    tot = (sa ? -big_v : big_v) + (sb ? -small_v : small_v);
    if (tot == 0) return {3'b000, sa & sb, 31'h0};
    s = (tot < 0);
    mag = s ? -tot : tot;
    p = 0;
    for (int i = 0; i < 62; i++) if (mag[i]) p = i;
    en = ea + p - 57;
    if (en <= 0) return {3'b010, s, 31'h0};
    if (p > 23) begin
      sh = p - 23;
      keep = mag >>> sh;
      rem = mag & ((64'sd1 <<< sh) - 1);
      half = 64'sd1 <<< (sh - 1);
      if (rem > half || (rem == half && keep[0])) keep = keep + 1;
      if (keep == (64'sd1 <<< 24)) begin
        keep = keep >>> 1;
        en = en + 1;
      end
    end else begin
      keep = mag <<< (23 - p);
    end
    if (en >= 255) return {3'b100, s, 8'hFF, 23'h0};
    return {3'b000, s, en[7:0], keep[22:0]};
  endfunction

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic sub, input string tag);
    logic [35:0] e;
    string t;
    @(negedge clk);
    if (exp_q.size() == 2) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (out_valid !== e[35]) begin
        errors++;
        $display("FAIL %s R1 out_valid: actual=%0b expected=%0b", t, out_valid, e[35]);
      end else if (e[35] && ({flag_ovf, flag_unf, flag_inv, result} !== e[34:0])) begin
        errors++;
        $display("FAIL %s result: actual=%b_%h expected=%b_%h", t,
                 {flag_ovf, flag_unf, flag_inv}, result, e[34:32], e[31:0]);
      end
    end
    in_valid = v; a_in = a; b_in = b; op_sub = sub;
    exp_q.push_back({v, (v ? ref_model(a, b, sub) : 35'h0)});
    tag_q.push_back(tag);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] ra, rb, tmp;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== 32'h0 || {flag_ovf, flag_unf, flag_inv} !== 3'b000) begin
      errors++;
      $display("FAIL R1 reset state: actual=%b_%h expected=0000_00000000",
               {out_valid, flag_ovf, flag_unf, flag_inv}, result);
    end
    @(negedge clk);
    rst = 1'b0;

    // R2: add and subtract
    step(1, 32'h3F80_0000, 32'h3F80_0000, 0, "R2 1+1");
    step(1, 32'h4040_0000, 32'h40A0_0000, 1, "R2 3-5");
    step(0, 32'h0, 32'h0, 0, "R1 idle gap");
    step(1, 32'h3F80_0000, 32'h7F80_0000, 1, "R2 1-inf");
    // R5: signed zeros
    step(1, 32'h3F80_0000, 32'h3F80_0000, 1, "R5 1-1");
    step(1, 32'h8000_0000, 32'h8000_0000, 0, "R5 -0+-0");
    step(1, 32'h0000_0000, 32'h8000_0000, 0, "R5 +0+-0");
    step(1, 32'h8000_0000, 32'h0000_0000, 1, "R5 -0-+0");
    // R6: zero operand
    step(1, 32'h0000_0000, 32'h4049_0FDB, 0, "R6 0+x");
    step(1, 32'hC049_0FDB, 32'h8000_0000, 0, "R6 x+-0");
    step(1, 32'h0000_0000, 32'h4049_0FDB, 1, "R6 0-x");
    // R3: ties to even
    step(1, 32'h3F80_0000, 32'h3380_0000, 0, "R3 tie even down");
    step(1, 32'h3F80_0001, 32'h3380_0000, 0, "R3 tie odd up");
    step(1, 32'h3F80_0000, 32'h3380_0001, 0, "R3 above half");
    // R11: cancellation
    step(1, 32'h3F80_0000, 32'h3F7F_FFFF, 1, "R11 near-equal");
    step(1, 32'h4120_0001, 32'h4120_0000, 1, "R11 low bit");
    // R7: overflow
    step(1, 32'h7F7F_FFFF, 32'h7F7F_FFFF, 0, "R7 max+max");
    step(1, 32'h7F7F_FFFF, 32'h7300_0000, 0, "R7 round to inf");
    step(1, 32'hFF7F_FFFF, 32'h7F7F_FFFF, 1, "R7 -max-max");
    // R8: underflow
    step(1, 32'h0080_0000, 32'h0080_0001, 1, "R8 tiny negative");
    step(1, 32'h00FF_FFFF, 32'h0080_0000, 1, "R8 subnormal diff");
    // R4: subnormal decode
    step(1, 32'h0000_0001, 32'h0080_0000, 0, "R4 sub+min normal");
    step(1, 32'h0040_0000, 32'h0040_0000, 0, "R4 sub+sub normal");
    // R9: NaNs
    step(1, 32'h7FC0_0000, 32'h3F80_0000, 0, "R9 qnan a");
    step(1, 32'h3F80_0000, 32'h7F80_0001, 0, "R9 snan b");
    step(1, 32'hFFC0_0001, 32'h7F80_0000, 1, "R9 neg nan");
    // R10: infinities
    step(1, 32'h7F80_0000, 32'h3F80_0000, 0, "R10 inf+1");
    step(1, 32'hFF80_0000, 32'h7F7F_FFFF, 0, "R10 -inf+max");
    step(1, 32'h7F80_0000, 32'h7F80_0000, 0, "R10 inf+inf");
    step(1, 32'h7F80_0000, 32'h7F80_0000, 1, "R10 inf-inf");
    step(1, 32'h7F80_0000, 32'hFF80_0000, 0, "R10 inf+-inf");

    // R3: mixed random coverage
    for (int i = 0; i < 600; i++) begin
      ra = rnd();
      tmp = rnd();
      rb = rnd();
      if (i % 5 == 0) ra[30:23] = {4'b0000, tmp[3:0]};
      if (i % 3 == 1) rb = {tmp[31], ra[30:23] - {5'd0, tmp[6:4]}, rb[22:0]};
      if (i % 3 == 2) rb = ra ^ {23'd0, tmp[8:0]};
      step(i % 7 != 3, ra, rb, (i % 3 == 2) ? 1'b1 : tmp[12], "R3 random");
    end

    step(0, 32'h0, 32'h0, 0, "R1 drain");
    step(0, 32'h0, 32'h0, 0, "R1 drain");
    step(0, 32'h0, 32'h0, 0, "R1 drain");
    summary();
    $finish;
  end

endmodule